// File: doc/BRIEF.md
# Periodic and One-Shot Countdown Timer

This block is a down-counter with a programmable clock divider in front of it. A period value sets how many clock cycles pass between two decrements. A limit value is the number that the counter reloads. The timer has three run modes: off, cyclic and single. In cyclic mode it reloads from the limit every time it expires and runs on. In single mode it expires once and then turns itself off. Each expiry produces a one-cycle pulse.

Control is through single-cycle command strobes: stop, start (cyclic or single), write count, write limit (with an optional reload-now flag) and write period. Stop wins over start, and start wins over the writes. Any write that arrives in the same cycle as a stop or a start is dropped. While the timer runs, the count output shows the live value. While it is off, the count output holds its last value. A zero period or a zero reload value can never be left running: when either appears, the timer turns off.

Top module: `countdown_timer`

## Requirements
- R1: After reset the mode output is 0, the count is 0 and the expiry output is low. The mode encoding is 0 for off, 1 for cyclic and 2 for single.
- R2: In cyclic mode, when the count steps from 1, the expiry output is high for exactly one cycle. In that same cycle the count shows the limit value, and counting goes on.
- R3: In single mode, when the count steps from 1, the expiry output pulses. The mode then reads 0 and the count reads 0.
- R4: With period P, the count drops by one on every P-th clock edge after the edge that started or restarted the interval.
- R5: A start strobe while the mode is nonzero has no effect, and counting continues. A start strobe while the period is 0 is rejected, and the mode stays 0.
- R6: If a start or restart finds the count at zero, the expiry output pulses and the count loads the limit. If that limit is also zero, the mode goes to 0.
- R7: A stop strobe holds the live count and sets the mode to 0. Any write in the same cycle is dropped, and the held count then stays unchanged.
- R8: A limit write with the reload flag set loads the count and restarts the interval. Without the flag, only the limit changes and the count goes on as before.
- R9: A count write while running loads the new value and restarts the interval from that edge.
- R10: A period write while running restarts the interval from that edge. A period write of 0 while running sets the mode to 0 and keeps the count.
- R11: While the mode is 0, the count output holds its value, and a count write replaces that value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stopCmd | input | 1 | Stop strobe |
| startCmd | input | 1 | Start strobe |
| startSingle | input | 1 | With start: 1 selects single mode, 0 selects cyclic mode |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 32 | Count write value |
| limWrEn | input | 1 | Limit write strobe |
| limWrData | input | 32 | Limit write value |
| limReload | input | 1 | With a limit write: also load the count |
| perWrEn | input | 1 | Period write strobe |
| perWrData | input | 16 | Clock cycles per decrement |
| countOut | output | 32 | Live or held count |
| modeOut | output | 2 | 0 off, 1 cyclic, 2 single |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The bench goes after the cycle on which expiry occurs. A design that is off by one in the divider would pulse one period early or late, or would show a count that never reaches the limit.

The bench also targets restarts. It places count and period writes exactly on a due decrement edge. A design that keeps its old divider phase would drop an extra count on that edge.

Zero cases get their own tests: a start with a zero count, a zero limit, and a zero period. A design that mishandles them would sit in a running mode that can never expire.

The last group covers command priority: a stop combined with a write, and a start while running. A wrong priority order would corrupt the held count or switch the mode.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    TMR_OFF    = 2'd0,
    TMR_CYCLIC = 2'd1,
    TMR_SINGLE = 2'd2
  } tmr_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrCnt;      // load count from count write data
    logic wrLim;      // load limit register
    logic wrLimCnt;   // load count from limit write data
    logic wrPer;      // load period register
    logic reloadLim;  // load count from the (new) limit
    logic dec;        // decrement count
    logic clrPre;     // clear prescaler
    logic runPre;     // advance prescaler
  } tmr_ctl_t;

endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctl_t         ctl,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic [CNT_W-1:0] limWrData,
  input  logic [PER_W-1:0] perWrData,
  output logic [CNT_W-1:0] countVal,
  output logic             limZero,
  output logic             perZero,
  output logic             cntZero,
  output logic             cntOne,
  output logic             preWrap
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] limitReg;
  logic [PER_W-1:0] periodReg;
  logic [PER_W-1:0] preCnt;
  logic [CNT_W-1:0] nextLimit;

  assign nextLimit = ctl.wrLim ? limWrData : limitReg;

  always_ff @(posedge clk) begin
    if (!rst_n)             countReg <= '0;
    else if (ctl.reloadLim) countReg <= nextLimit;
    else if (ctl.wrCnt)     countReg <= cntWrData;
    else if (ctl.wrLimCnt)  countReg <= limWrData;
    else if (ctl.dec)       countReg <= countReg - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         limitReg <= '0;
    else if (ctl.wrLim) limitReg <= limWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         periodReg <= '0;
    else if (ctl.wrPer) periodReg <= perWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          preCnt <= '0;
    else if (ctl.clrPre) preCnt <= '0;
    else if (ctl.runPre) preCnt <= preWrap ? '0 : preCnt + PER_ONE;
  end

  assign preWrap  = (periodReg != '0) && (preCnt == periodReg - PER_ONE);
  assign limZero  = (limitReg == '0);
  assign perZero  = (periodReg == '0);
  assign cntZero  = (countReg == '0);
  assign cntOne   = (countReg == CNT_ONE);
  assign countVal = countReg;

  // R4: a lone decrement strobe lowers the count by exactly one
  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.dec && !ctl.reloadLim && !ctl.wrCnt && !ctl.wrLimCnt)
      |=> (countReg == $past(countReg) - CNT_ONE));

  // R4: prescaler stays below a nonzero period
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.runPre && !ctl.wrPer) |=> (preCnt < periodReg) || (preCnt == '0));

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopCmd,
  input  logic             startCmd,
  input  logic             startSingle,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             limWrEn,
  input  logic [CNT_W-1:0] limWrData,
  input  logic             limReload,
  input  logic             perWrEn,
  input  logic [PER_W-1:0] perWrData,
  input  logic             limZero,
  input  logic             perZero,
  input  logic             cntZero,
  input  logic             cntOne,
  input  logic             preWrap,
  output tmr_ctl_t         ctl,
  output tmr_mode_e        mode,
  output logic             expire
);

  tmr_mode_e modeNext;
  logic      expNext;
  logic      writesOk;
  logic      restartReq;
  logic      newLimZero;
  logic      newPerZero;
  logic      startVal0;
  logic      running;

  assign running = (mode != TMR_OFF);

  always_comb begin
    ctl      = '0;
    modeNext = mode;
    expNext  = 1'b0;

    writesOk     = !stopCmd && !startCmd;
    ctl.wrCnt    = writesOk && cntWrEn;
    ctl.wrLim    = writesOk && limWrEn;
    ctl.wrLimCnt = writesOk && limWrEn && limReload;
    ctl.wrPer    = writesOk && perWrEn;

    newLimZero = ctl.wrLim ? (limWrData == '0) : limZero;
    newPerZero = ctl.wrPer ? (perWrData == '0) : perZero;
    restartReq = ctl.wrCnt || ctl.wrLimCnt || ctl.wrPer;
    startVal0  = ctl.wrCnt    ? (cntWrData == '0) :
                 ctl.wrLimCnt ? (limWrData == '0) : cntZero;

    if (stopCmd) begin
      modeNext   = TMR_OFF;
      ctl.clrPre = 1'b1;
    end else if (startCmd && !running) begin
      if (!perZero) begin
        ctl.clrPre = 1'b1;
        modeNext   = startSingle ? TMR_SINGLE : TMR_CYCLIC;
        if (cntZero) begin
          expNext       = 1'b1;
          ctl.reloadLim = 1'b1;
          if (limZero) modeNext = TMR_OFF;
        end
      end
    end else if (running && restartReq) begin
      ctl.clrPre = 1'b1;
      if (startVal0) begin
        expNext       = 1'b1;
        ctl.reloadLim = 1'b1;
        if (newLimZero) modeNext = TMR_OFF;
      end
      if (newPerZero) modeNext = TMR_OFF;
    end else if (running) begin
      ctl.runPre = 1'b1;
      if (preWrap) begin
        if (cntOne) begin
          expNext = 1'b1;
          if (mode == TMR_SINGLE) begin
            ctl.dec  = 1'b1;
            modeNext = TMR_OFF;
          end else begin
            ctl.reloadLim = 1'b1;
            if (newLimZero) modeNext = TMR_OFF;
          end
        end else begin
          ctl.dec = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= TMR_OFF;
      expire <= 1'b0;
    end else begin
      mode   <= modeNext;
      expire <= expNext;
    end
  end

  // R1: only the three defined mode codes appear
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  // R7: stop always lands in off
  p_stop_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stopCmd |=> (mode == TMR_OFF));

  // R6, R10: a running timer never holds a zero count or zero period
  p_run_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (!cntZero && !perZero));

  // R3: single mode ends at expiry
  p_single_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TMR_SINGLE && !stopCmd && !restartReq && preWrap && cntOne)
      |=> (mode == TMR_OFF) && expire);

  // R5: start while running does not change the mode
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && startCmd && !stopCmd && !(preWrap && cntOne))
      |=> (mode == $past(mode)));

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopCmd,
  input  logic             startCmd,
  input  logic             startSingle,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             limWrEn,
  input  logic [CNT_W-1:0] limWrData,
  input  logic             limReload,
  input  logic             perWrEn,
  input  logic [PER_W-1:0] perWrData,
  output logic [CNT_W-1:0] countOut,
  output logic [1:0]       modeOut,
  output logic             expire
);

  tmr_ctl_t  ctl;
  tmr_mode_e mode;
  logic      limZero;
  logic      perZero;
  logic      cntZero;
  logic      cntOne;
  logic      preWrap;

  timer_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .stopCmd(stopCmd), .startCmd(startCmd), .startSingle(startSingle),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .limWrEn(limWrEn), .limWrData(limWrData), .limReload(limReload),
    .perWrEn(perWrEn), .perWrData(perWrData),
    .limZero(limZero), .perZero(perZero), .cntZero(cntZero),
    .cntOne(cntOne), .preWrap(preWrap),
    .ctl(ctl), .mode(mode), .expire(expire)
  );

  timer_datapath #(.CNT_W(CNT_W), .PER_W(PER_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .cntWrData(cntWrData), .limWrData(limWrData), .perWrData(perWrData),
    .countVal(countOut), .limZero(limZero), .perZero(perZero),
    .cntZero(cntZero), .cntOne(cntOne), .preWrap(preWrap)
  );

  assign modeOut = mode;

endmodule

// File: tb/test_countdown_timer.sv
module test_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stopCmd = 0, startCmd = 0, startSingle = 0;
  logic        cntWrEn = 0, limWrEn = 0, limReload = 0, perWrEn = 0;
  logic [31:0] cntWrData = '0, limWrData = '0;
  logic [15:0] perWrData = '0;
  logic [31:0] countOut;
  logic [1:0]  modeOut;
  logic        expire;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  countdown_timer i_countdown_timer (
    .clk(clk), .rst_n(rst_n),
    .stopCmd(stopCmd), .startCmd(startCmd), .startSingle(startSingle),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .limWrEn(limWrEn), .limWrData(limWrData), .limReload(limReload),
    .perWrEn(perWrEn), .perWrData(perWrData),
    .countOut(countOut), .modeOut(modeOut), .expire(expire)
  );

  // Vector table: period, limit, start count, single?, edges, expected count, expected mode
  localparam int NV = 7;
  localparam int vPer [NV] = '{1, 4, 2, 3, 1, 5, 2};
  localparam int vLim [NV] = '{10, 5, 3, 4, 6, 9, 7};
  localparam int vCnt [NV] = '{10, 5, 3, 2, 6, 9, 4};
  localparam int vOne [NV] = '{0, 0, 0, 0, 1, 1, 1};
  localparam int vK   [NV] = '{3, 13, 8, 9, 10, 12, 8};
  localparam int vExC [NV] = '{7, 2, 2, 3, 0, 7, 0};
  localparam int vExM [NV] = '{1, 1, 1, 1, 0, 2, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic s, input logic st, input logic os,
                     input logic ce, input logic [31:0] cd,
                     input logic le, input logic [31:0] ld, input logic lr,
                     input logic pe, input logic [15:0] pd);
    stopCmd = s; startCmd = st; startSingle = os;
    cntWrEn = ce; cntWrData = cd;
    limWrEn = le; limWrData = ld; limReload = lr;
    perWrEn = pe; perWrData = pd;
    @(posedge clk);
    @(negedge clk);
    stopCmd = 0; startCmd = 0; startSingle = 0;
    cntWrEn = 0; limWrEn = 0; limReload = 0; perWrEn = 0;
  endtask

  task automatic doStop();             cmd(1,0,0, 0,0, 0,0,0, 0,0); endtask
  task automatic doStart(input logic os); cmd(0,1,os, 0,0, 0,0,0, 0,0); endtask
  task automatic wrCnt(input int v);   cmd(0,0,0, 1,v, 0,0,0, 0,0); endtask
  task automatic wrLim(input int v, input logic rl); cmd(0,0,0, 0,0, 1,v,rl, 0,0); endtask
  task automatic wrPer(input int v);   cmd(0,0,0, 0,0, 0,0,0, 1,16'(v)); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(modeOut), 0);
    chk("R1 count", countOut, 0);
    chk("R1 expire", 32'(expire), 0);

    // Table walk: R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      doStop();
      wrPer(vPer[i]);
      wrLim(vLim[i], 1'b1);
      if (vCnt[i] != vLim[i]) wrCnt(vCnt[i]);
      doStart(vOne[i] != 0);
      waitEdges(vK[i]);
      chk($sformatf("R4 vec%0d count", i), countOut, vExC[i]);
      chk($sformatf("R2/R3 vec%0d mode", i), 32'(modeOut), vExM[i]);
    end

    // R2: cyclic expiry edge and reload
    doStop(); wrPer(2); wrLim(3, 1'b1); doStart(1'b0);
    waitEdges(5);
    chk("R2 no early expire", 32'(expire), 0);
    waitEdges(1);
    chk("R2 expire pulse", 32'(expire), 1);
    chk("R2 reload limit", countOut, 3);
    waitEdges(1);
    chk("R2 pulse one cycle", 32'(expire), 0);

    // R3: single expiry
    doStop(); wrPer(1); wrLim(2, 1'b1); doStart(1'b1);
    waitEdges(2);
    chk("R3 expire", 32'(expire), 1);
    chk("R3 mode off", 32'(modeOut), 0);
    chk("R3 count zero", countOut, 0);

    // R6: start with zero count loads limit
    wrLim(5, 1'b0);
    doStart(1'b0);
    chk("R6 expire on zero start", 32'(expire), 1);
    chk("R6 count from limit", countOut, 5);
    chk("R6 mode cyclic", 32'(modeOut), 1);
    doStop(); wrLim(0, 1'b0); wrCnt(0); doStart(1'b0);
    chk("R6 zero limit expire", 32'(expire), 1);
    chk("R6 zero limit off", 32'(modeOut), 0);

    // R5: start ignored while running; zero period rejected
    doStop(); wrPer(1); wrLim(10, 1'b1); doStart(1'b0);
    waitEdges(3);
    doStart(1'b1);
    chk("R5 start ignored mode", 32'(modeOut), 1);
    chk("R5 start ignored count", countOut, 6);
    doStop(); wrPer(0); doStart(1'b0);
    chk("R5 zero period rejected", 32'(modeOut), 0);

    // R7: stop with simultaneous write
    wrPer(1); wrLim(20, 1'b1); doStart(1'b0);
    waitEdges(4);
    chk("R7 pre-stop count", countOut, 16);
    cmd(1,0,0, 1,99, 0,0,0, 0,0);
    chk("R7 held count", countOut, 16);
    chk("R7 mode off", 32'(modeOut), 0);
    waitEdges(5);
    chk("R7 count stays", countOut, 16);

    // R8: limit writes with and without reload
    wrLim(30, 1'b0);
    chk("R8 no-flag keeps count", countOut, 16);
    doStart(1'b0);
    waitEdges(2);
    chk("R8 running count", countOut, 14);
    wrLim(50, 1'b1);
    chk("R8 reload loads count", countOut, 50);
    waitEdges(2);
    chk("R8 restart count", countOut, 48);
    wrLim(40, 1'b0);
    chk("R8 no-flag running", countOut, 47);

    // R9: count write on a due edge restarts interval
    doStop(); wrPer(3); wrCnt(10); doStart(1'b0);
    waitEdges(2);
    wrCnt(7);
    waitEdges(2);
    chk("R9 restart holds", countOut, 7);
    waitEdges(1);
    chk("R9 first step", countOut, 6);

    // R10: period write restarts interval; zero period stops
    doStop(); wrPer(4); wrCnt(10); doStart(1'b0);
    waitEdges(3);
    wrPer(2);
    waitEdges(1);
    chk("R10 restart holds", countOut, 10);
    waitEdges(1);
    chk("R10 new period step", countOut, 9);
    wrPer(0);
    chk("R10 zero period off", 32'(modeOut), 0);
    chk("R10 count kept", countOut, 9);

    // R11: held count while off
    wrCnt(123);
    chk("R11 write while off", countOut, 123);
    waitEdges(4);
    chk("R11 held", countOut, 123);
    chk("R11 mode off", 32'(modeOut), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule